// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Holding Buffer

This block turns bytes written by a processor into asynchronous serial frames on a single output line. A byte written on the parallel side lands in a one-entry holding buffer. When the shift stage is free, and the transmit enable is on, the byte moves into a frame shifter. The shifter sends a low start bit, the eight data bits least significant first, and a high stop bit. The line rests high between frames.

Bit timing comes only from a separate transmit clock input. That input is synchronised into the system clock domain, and its rising edges are counted. Each serial bit lasts 1, 16 or 64 transmit-clock periods, chosen by a rate select input. The system clock only runs the parallel interface and the sampling logic. A break control pulls the line low for as long as it is held. A ready output tells the processor when the holding buffer can take another byte. Because the buffer can hold a byte while a frame is still going out, frames can follow each other with no idle gap.

Top module: `serial_tx_unit`

## Requirements
- R1: After reset, txd is high and tx_ready is high.
- R2: A frame on txd is one low start bit, then wr_data[0] through wr_data[7] in that order, then one high stop bit. With no frame in progress and no break, txd is high.
- R3: Each bit, start and stop included, lasts exactly F periods of txc. F is set by rate_sel: 2'b00 gives 1, 2'b01 gives 16, and 2'b10 or 2'b11 gives 64.
- R4: tx_ready is high exactly when the holding buffer is empty. It goes low the cycle after an accepted write, and it is high again once the byte has moved into the shifter, which happens by the start of that byte's start bit.
- R5: A byte written while a frame is in flight is held. Its start bit begins at the very end of the current stop bit, so two start edges are exactly 10·F txc periods apart.
- R6: A write while tx_ready is low is ignored. The held byte is kept and sent, and the ignored byte never appears on txd.
- R7: While tx_en is low, no new frame starts: txd stays high and a held byte stays in the buffer (tx_ready low). Raising tx_en later sends it.
- R8: While brk_cmd is high, txd is low in every cycle. When brk_cmd is released with nothing in flight, txd returns high.
- R9: Dropping tx_en during a frame does not cut it short. That frame completes intact.
- R10: Bit timing follows txc and not clk. A frame's start bit begins only on a synchronised rising edge of txc, and changing the txc period scales every bit length with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the parallel side and txc sampling |
| rst | input | 1 | Synchronous reset, active high |
| txc | input | 1 | Transmit bit-rate clock, asynchronous to clk |
| wr_stb | input | 1 | One-cycle write strobe for the holding buffer |
| wr_data | input | DATA_W | Byte to be sent |
| rate_sel | input | 2 | Bit length select: 1, 16 or 64 txc periods |
| tx_en | input | 1 | Allows new frames to start |
| brk_cmd | input | 1 | Forces txd low while high |
| txd | output | 1 | Serial output line |
| tx_ready | output | 1 | High when the holding buffer is empty |

## Verification
A holding buffer stuck full or stuck empty shows on tx_ready within a cycle of a write, and as a missing or repeated frame one frame time later. A divider that counts wrongly shows at once as a start bit of the wrong length, so the bench times the start bit at every rate and under two txc periods. A shifter that loses its place shows as wrong data bits or a low stop bit within the same frame. A missing start condition in the back-to-back case shows as a gap between two start edges that is not 10·F periods.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam int DIV_W = 7;

  typedef enum logic [1:0] {
    RATE_X1      = 2'b00,
    RATE_X16     = 2'b01,
    RATE_X64     = 2'b10,
    RATE_X64_ALT = 2'b11
  } rate_e;

  // Number of txc periods per serial bit for a rate code.
  function automatic logic [DIV_W-1:0] rate_factor(input logic [1:0] sel);
    logic [DIV_W-1:0] f;
    case (rate_e'(sel))
      RATE_X1:  f = DIV_W'(1);
      RATE_X16: f = DIV_W'(16);
      default:  f = DIV_W'(64);
    endcase
    return f;
  endfunction

  // Terminal count of the bit divider for a rate code.
  function automatic logic [DIV_W-1:0] rate_last(input logic [1:0] sel);
    return rate_factor(sel) - DIV_W'(1);
  endfunction

endpackage

// File: rtl/txc_sync.sv
module txc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic txc_async,
  output logic txc_rise
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  generate
    for (genvar g = 0; g < CHAIN_W; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= txc_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // A rising edge is seen when the last synchronised stage is high
  // and the extra edge-detect stage is still low.
  assign txc_rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/bit_timer.sv
module bit_timer
  import serial_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       txc_tick,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] rate_sel,
  output logic       bit_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_cnt;
  logic             at_last;

  assign last_cnt = rate_last(rate_sel);
  assign at_last  = (cnt_q == last_cnt);
  assign bit_tick = run & txc_tick & at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart || !run) begin
      cnt_q <= '0;
    end else if (txc_tick) begin
      cnt_q <= at_last ? '0 : cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/hold_buffer.sv
module hold_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  // A write is taken only into an empty buffer.
  assign accept = wr_stb & ~full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= wr_data;
    end
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              bit_tick,
  output logic              busy,
  output logic              line,
  output logic              frame_end
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   idx_q;
  logic               busy_q;

  // Stop bit on top, start bit at the bottom; shifted out from bit 0.
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [DATA_W-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  assign frame_end = busy_q & bit_tick & (idx_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '1;
      idx_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load) begin
      shreg_q <= pack_frame(load_data);
      idx_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q && bit_tick) begin
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      if (idx_q == LAST_BIT) begin
        idx_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + CNT_W'(1);
      end
    end
  end

  assign busy = busy_q;
  assign line = busy_q ? shreg_q[0] : 1'b1;

endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txc,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rate_sel,
  input  logic              tx_en,
  input  logic              brk_cmd,
  output logic              txd,
  output logic              tx_ready
);
  // Named internal events, also used by the bound checker.
  logic              txc_tick;
  logic              bit_tick;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              sh_busy;
  logic              sh_line;
  logic              frame_end;
  logic              load;

  txc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .txc_async (txc),
    .txc_rise  (txc_tick)
  );

  hold_buffer #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .take    (load),
    .full    (buf_full),
    .data    (buf_data)
  );

  // A frame starts on a txc edge, either from idle or exactly where
  // the previous stop bit ends.
  assign load = buf_full & tx_en & txc_tick & (~sh_busy | frame_end);

  bit_timer u_timer (
    .clk      (clk),
    .rst      (rst),
    .txc_tick (txc_tick),
    .run      (sh_busy),
    .restart  (load),
    .rate_sel (rate_sel),
    .bit_tick (bit_tick)
  );

  frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (buf_data),
    .bit_tick  (bit_tick),
    .busy      (sh_busy),
    .line      (sh_line),
    .frame_end (frame_end)
  );

  assign txd      = brk_cmd ? 1'b0 : sh_line;
  assign tx_ready = ~buf_full;

endmodule

// File: rtl/serial_tx_checker.sv
module serial_tx_checker (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic brk_cmd,
  input logic wr_stb,
  input logic txd,
  input logic tx_ready,
  input logic busy,
  input logic buf_full,
  input logic load,
  input logic txc_tick,
  input logic frame_end
);

  AST_RESET_STATE: assert property (@(posedge clk) $fell(rst) |-> (txd || brk_cmd) && tx_ready); // R1
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst) (!busy && !brk_cmd) |-> txd); // R2
  AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (rst) (frame_end && !brk_cmd) |-> txd); // R2
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst) (wr_stb && tx_ready) |=> !tx_ready); // R4
  AST_FULL_KEPT: assert property (@(posedge clk) disable iff (rst) (buf_full && !load) |=> buf_full); // R6
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst) (!tx_en && !busy) |=> !busy); // R7
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst) brk_cmd |-> !txd); // R8
  AST_START_ON_TXC: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(txc_tick)); // R10

endmodule

bind serial_tx_unit serial_tx_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_en     (tx_en),
  .brk_cmd   (brk_cmd),
  .wr_stb    (wr_stb),
  .txd       (txd),
  .tx_ready  (tx_ready),
  .busy      (sh_busy),
  .buf_full  (buf_full),
  .load      (load),
  .txc_tick  (txc_tick),
  .frame_end (frame_end)
);

// File: tb/serial_tx_unit_tb_top.sv
module serial_tx_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txc = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rate_sel = 2'b00;
  logic       tx_en = 1'b1;
  logic       brk_cmd = 1'b0;
  logic       txd;
  logic       tx_ready;

  int errors = 0;
  int checks = 0;
  int txc_half = 2;   // txc half period in clk cycles
  int cyc = 0;
  bit done = 0;

  serial_tx_unit dut_i (
    .clk(clk), .rst(rst), .txc(txc), .wr_stb(wr_stb), .wr_data(wr_data),
    .rate_sel(rate_sel), .tx_en(tx_en), .brk_cmd(brk_cmd),
    .txd(txd), .tx_ready(tx_ready)
  );

  always #4 clk = ~clk;                   // 125 MHz
  always begin #(txc_half * 8); txc = ~txc; end
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int factor_of(input logic [1:0] s);
    if (s == 2'b00) return 1;
    if (s == 2'b01) return 16;
    return 64;
  endfunction

  function automatic int bit_len();
    return factor_of(rate_sel) * 2 * txc_half;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] d);
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic wait_fall(output int t0);
    int n = 0;
    @(negedge clk);
    while (txd !== 1'b0 && n < 30000) begin @(negedge clk); n++; end
    t0 = cyc;
    chk(txd === 1'b0, "R2 start edge seen", int'(txd), 0);
  endtask

  // Receives one frame, sampling each bit in its middle.
  task automatic capture(output logic [7:0] d, output int t0, output bit rdy_at_start);
    int bl;
    bl = bit_len();
    wait_fall(t0);
    rdy_at_start = tx_ready;
    repeat (bl / 2) @(negedge clk);
    chk(txd === 1'b0, "R2 start bit low", int'(txd), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bl) @(negedge clk);
      d[i] = txd;
    end
    repeat (bl) @(negedge clk);
    chk(txd === 1'b1, "R2 stop bit high", int'(txd), 1);
  endtask

  task automatic measure_start(output int len);
    int t0;
    wait_fall(t0);
    len = 0;
    while (txd === 1'b0 && len < 1000) begin len++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(tx_ready === 1'b1, "R1 tx_ready after reset", int'(tx_ready), 1);
  endtask

  task automatic t_frame(input logic [1:0] s, input logic [7:0] v);
    logic [7:0] d; int t0; bit r;
    rate_sel = s;
    cpu_write(v);
    chk(tx_ready === 1'b0, "R4 ready low after write", int'(tx_ready), 0);
    capture(d, t0, r);
    chk(d == v, "R2 data bits", int'(d), int'(v));
    chk(r == 1'b1, "R4 ready high once loaded", int'(r), 1);
    repeat (bit_len()) @(negedge clk);
    chk(txd === 1'b1, "R2 idle high after frame", int'(txd), 1);
  endtask

  task automatic t_rate(input logic [1:0] s, input string tag);
    int len;
    rate_sel = s;
    cpu_write(8'h01);
    measure_start(len);
    chk(len == bit_len(), tag, len, bit_len());
    repeat (10 * bit_len()) @(negedge clk);
  endtask

  task automatic t_back_to_back();
    logic [7:0] da, db; int ta, tb; bit r;
    rate_sel = 2'b01;
    cpu_write(8'h96);
    fork
      begin capture(da, ta, r); capture(db, tb, r); end
      begin
        while (tx_ready !== 1'b1) @(negedge clk);
        cpu_write(8'h4B);
      end
    join
    chk(da == 8'h96, "R5 first frame", int'(da), 8'h96);
    chk(db == 8'h4B, "R5 second frame", int'(db), 8'h4B);
    chk(tb - ta == 10 * bit_len(), "R5 no gap between frames", tb - ta, 10 * bit_len());
    repeat (bit_len()) @(negedge clk);
  endtask

  task automatic t_disabled();
    logic [7:0] d; int t0; bit r; int highs = 0;
    rate_sel = 2'b00;
    tx_en = 1'b0;
    cpu_write(8'h5A);
    cpu_write(8'hFF);
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (txd === 1'b1) highs++; end
    chk(highs == 100, "R7 txd high while disabled", highs, 100);
    chk(tx_ready === 1'b0, "R7 byte held while disabled", int'(tx_ready), 0);
    tx_en = 1'b1;
    capture(d, t0, r);
    chk(d == 8'h5A, "R6 held byte sent, write while full ignored", int'(d), 8'h5A);
    highs = 0;
    for (int i = 0; i < 12 * bit_len(); i++) begin @(negedge clk); if (txd === 1'b1) highs++; end
    chk(highs == 12 * bit_len(), "R6 ignored byte never sent", highs, 12 * bit_len());
    chk(tx_ready === 1'b1, "R6 buffer empty after", int'(tx_ready), 1);
  endtask

  task automatic t_enable_drop();
    logic [7:0] d; int t0; bit r;
    rate_sel = 2'b01;
    cpu_write(8'hC3);
    fork
      capture(d, t0, r);
      begin
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (3) @(negedge clk);
        tx_en = 1'b0;
        cpu_write(8'h77);
      end
    join
    chk(d == 8'hC3, "R9 frame completes after enable drop", int'(d), 8'hC3);
    repeat (12 * bit_len()) @(negedge clk);
    chk(txd === 1'b1, "R7 no frame after enable drop", int'(txd), 1);
    chk(tx_ready === 1'b0, "R7 second byte held", int'(tx_ready), 0);
    tx_en = 1'b1;
    capture(d, t0, r);
    chk(d == 8'h77, "R7 held byte sent on enable", int'(d), 8'h77);
    repeat (bit_len()) @(negedge clk);
  endtask

  task automatic t_break();
    int highs = 0;
    rate_sel = 2'b00;
    @(negedge clk); brk_cmd = 1'b1;
    @(negedge clk);
    chk(txd === 1'b0, "R8 break forces low at idle", int'(txd), 0);
    cpu_write(8'hFF);
    for (int i = 0; i < 14 * bit_len(); i++) begin @(negedge clk); if (txd !== 1'b0) highs++; end
    chk(highs == 0, "R8 low during frame under break", highs, 0);
    brk_cmd = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R8 line high after break", int'(txd), 1);
  endtask

  task automatic t_txc_scale();
    @(negedge clk); txc_half = 3;
    repeat (20) @(negedge clk);
    t_rate(2'b00, "R10 x1 bit with slower txc");
    t_rate(2'b01, "R10 x16 bit with slower txc");
    @(negedge clk); txc_half = 2;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_frame(2'b00, 8'hA5);
    t_frame(2'b01, 8'h3C);
    t_rate(2'b00, "R3 x1 bit length");
    t_rate(2'b01, "R3 x16 bit length");
    t_rate(2'b10, "R3 x64 bit length");
    t_rate(2'b11, "R3 x64 alt bit length");
    t_back_to_back();
    t_disabled();
    t_enable_drop();
    t_break();
    t_txc_scale();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule